// File: doc/BRIEF.md
# Latched Pseudo-SRAM Memory Front End

This block is a synthesizable device-side model of a word memory split into two byte lanes, reached through an asynchronous-SRAM style pin set. The pin set has a low-active primary select, a high-active secondary select, low-active write and read strobes, two low-active lane strobes, an address and a data bus. A fast internal clock samples every pin. Edges are found by comparing successive samples. From these the block works out the access mode, latches the word address on the edge that starts an access, and reads or writes the selected lanes of an internal array whose depth is a parameter.

The data bus is split into an input half and an output half, with one drive-enable per lane. A pad ring or bench builds the tristate bus from them. Two ways of starting an access are supported. In the first, the address is captured when the chip becomes selected. In the second, the chip is already selected and the address is captured when the read strobe or the write strobe falls. The block also watches how long the chip stays deselected between accesses. If a new access starts too early, it raises a sticky error. The block is meant as a protocol-checking partner for the bench of a memory controller.

Top module: `psram_port`

## Requirements
- R1: While `sel_n` is high or `sel_p` is low (standby), `lane_drive` is 2'b00 and no array word changes, whatever the other pins do.
- R2: When selected with `wr_n` high and `rd_n` low, each lane whose strobe is low has its `lane_drive` bit set and carries the stored byte. A lane whose strobe is high has its bit clear. Lane 0 is strobe bit 0, drive bit 0 and data bits 7:0. Lane 1 is bit 1 and data bits 15:8. Outputs follow a pin change after two clock edges.
- R3: A write changes only the lanes whose strobe is low. The other lanes keep their stored byte.
- R4: When the chip becomes selected with `rd_n` already low, the read address is the one sampled at the selecting edge. Later address changes during that access are ignored.
- R5: When `rd_n` falls while the chip is already selected, the word read is the one at the address sampled at that falling edge.
- R6: When `wr_n` falls while the chip is already selected, the address, data and lane strobes sampled at that edge are written. Later bus changes are ignored.
- R7: When the chip becomes selected with `wr_n` already low, the word is written when the chip is deselected. The address comes from the selecting edge, and the data and strobes from the last sample taken while selected.
- R8: `precharge_err` is set when an access starts after fewer than `PRECHG_MIN` deselected samples. A gap of exactly `PRECHG_MIN` samples is accepted.
- R9: `precharge_err` stays set until reset, and reset clears it to 0.
- R10: With `wr_n` and `rd_n` both low while selected, the cycle is a write and `lane_drive` stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Primary chip select, active low |
| sel_p | input | 1 | Secondary chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read (output) strobe, active low |
| lane_n | input | 2 | Lane strobes, active low, bit 0 = low byte |
| addr | input | AW | Word address |
| data_in | input | 16 | Bus value seen by the device |
| data_out | output | 16 | Read data for the lanes being driven |
| lane_drive | output | 2 | Per-lane drive enable for the bus |
| precharge_err | output | 1 | Sticky early-access error |

## Verification
The array is first filled word by word. The bench then issues a seeded random mix of four access styles, with random addresses, data and lane masks: select-started and strobe-started reads and writes. Every read is compared with a lane-masked reference model. In each style the bus is deliberately changed during the access. A design that latches on the wrong edge, or follows the address continuously, therefore returns the wrong word or byte, and this tells the four latching rules apart. Directed cases cover both forms of standby with every strobe asserted, writes with both strobes low, and precharge gaps one below and exactly at the minimum.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic                 sel_n;
        logic                 sel_p;
        logic                 wr_n;
        logic                 rd_n;
        logic [NUM_LANES-1:0] lane_n;
    } pin_ctl_t;

    typedef enum logic [1:0] {
        M_IDLE,
        M_NOP,
        M_READ,
        M_WRITE
    } acc_mode_e;

    localparam pin_ctl_t CTL_IDLE = '{sel_n: 1'b1, sel_p: 1'b0, wr_n: 1'b1,
                                      rd_n: 1'b1, lane_n: {NUM_LANES{1'b1}}};

    function automatic logic is_selected(pin_ctl_t c);
        return !c.sel_n && c.sel_p;
    endfunction

    // write wins over read when both strobes are low
    function automatic acc_mode_e decode_mode(pin_ctl_t c);
        if (!is_selected(c)) return M_IDLE;
        if (!c.wr_n)         return M_WRITE;
        if (!c.rd_n)         return M_READ;
        return M_NOP;
    endfunction

endpackage

// File: rtl/psram_sampler.sv
module psram_sampler
    import psram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  pin_ctl_t      ctl_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output pin_ctl_t      cur_ctl,
    output pin_ctl_t      prv_ctl,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_data,
    output logic [DW-1:0] prv_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ctl  <= CTL_IDLE;
            prv_ctl  <= CTL_IDLE;
            cur_addr <= '0;
            cur_data <= '0;
            prv_data <= '0;
        end else begin
            cur_ctl  <= ctl_in;
            prv_ctl  <= cur_ctl;
            cur_addr <= addr_in;
            cur_data <= data_in;
            prv_data <= cur_data;
        end
    end

endmodule

// File: rtl/psram_lanes.sv
module psram_lanes
    import psram_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANE_W = 8
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [NUM_LANES*LANE_W-1:0] wr_data,
    input  logic [NUM_LANES-1:0]        wr_mask,
    input  logic [AW-1:0]               rd_addr,
    output logic [NUM_LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l])
                mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            q <= mem[rd_addr];
        end

        assign rd_data[l*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int PRECHG_MIN = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_ctl_t             cur_ctl,
    input  pin_ctl_t             prv_ctl,
    input  logic [AW-1:0]        cur_addr,
    input  logic [DW-1:0]        cur_data,
    input  logic [DW-1:0]        prv_data,
    output logic                 wr_en,
    output logic [AW-1:0]        wr_addr,
    output logic [DW-1:0]        wr_data,
    output logic [NUM_LANES-1:0] wr_mask,
    output logic [AW-1:0]        rd_addr,
    output logic [NUM_LANES-1:0] drive,
    output logic                 proto_err
);

    localparam int PCW = $clog2(PRECHG_MIN + 2);
    localparam logic [PCW-1:0] PC_LIMIT = PCW'(PRECHG_MIN);

    logic           cur_sel, prv_sel;
    logic           sel_rise, sel_fall, rd_fall, wr_fall;
    logic           ce_wr;
    logic [AW-1:0]  lat_addr;
    logic [PCW-1:0] pc_cnt;
    acc_mode_e      mode;

    assign cur_sel  = is_selected(cur_ctl);
    assign prv_sel  = is_selected(prv_ctl);
    assign sel_rise = cur_sel && !prv_sel;
    assign sel_fall = !cur_sel && prv_sel;
    assign rd_fall  = cur_sel && prv_sel && !cur_ctl.rd_n && prv_ctl.rd_n;
    assign wr_fall  = cur_sel && prv_sel && !cur_ctl.wr_n && prv_ctl.wr_n;
    assign mode     = decode_mode(cur_ctl);

    // address: taken at the selecting edge or at a strobe fall inside an access
    always_ff @(posedge clk) begin
        if (rst)                              lat_addr <= '0;
        else if (sel_rise || rd_fall || wr_fall) lat_addr <= cur_addr;
    end

    // select-started write pending until deselect
    always_ff @(posedge clk) begin
        if (rst)                     ce_wr <= 1'b0;
        else if (sel_rise)           ce_wr <= !cur_ctl.wr_n;
        else if (sel_fall || wr_fall) ce_wr <= 1'b0;
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = lat_addr;
        wr_data = prv_data;
        wr_mask = ~prv_ctl.lane_n;
        if (wr_fall) begin
            wr_en   = 1'b1;
            wr_addr = cur_addr;
            wr_data = cur_data;
            wr_mask = ~cur_ctl.lane_n;
        end else if (sel_fall && ce_wr) begin
            wr_en = 1'b1;
        end
    end

    assign rd_addr = (sel_rise || rd_fall) ? cur_addr : lat_addr;

    always_ff @(posedge clk) begin
        if (rst)                  drive <= '0;
        else if (mode == M_READ)  drive <= ~cur_ctl.lane_n;
        else                      drive <= '0;
    end

    // precharge gap counter, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_cnt    <= PC_LIMIT;
            proto_err <= 1'b0;
        end else begin
            if (cur_sel)                pc_cnt <= '0;
            else if (pc_cnt < PC_LIMIT) pc_cnt <= pc_cnt + 1'b1;
            if (sel_rise && (pc_cnt < PC_LIMIT)) proto_err <= 1'b1;
        end
    end

    // R1
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cur_sel |=> (drive == '0));

    // R1
    standby_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (!cur_sel && !prv_sel) |-> !wr_en);

    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_sel && !cur_ctl.wr_n) |=> (drive == '0));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_sel && prv_sel && !rd_fall && !wr_fall) |=> $stable(lat_addr));

    // R7
    ce_wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_fall && ce_wr) |-> wr_en);

    // R8
    early_access_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_rise && (pc_cnt < PC_LIMIT)) |=> proto_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

endmodule

// File: rtl/psram_port.sv
module psram_port
    import psram_pkg::*;
#(
    parameter int AW         = 8,
    parameter int LANE_W     = 8,
    parameter int PRECHG_MIN = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sel_n,
    input  logic                        sel_p,
    input  logic                        wr_n,
    input  logic                        rd_n,
    input  logic [1:0]                  lane_n,
    input  logic [AW-1:0]               addr,
    input  logic [2*LANE_W-1:0]         data_in,
    output logic [2*LANE_W-1:0]         data_out,
    output logic [1:0]                  lane_drive,
    output logic                        precharge_err
);

    localparam int DW = NUM_LANES * LANE_W;

    pin_ctl_t             ctl_in, cur_ctl, prv_ctl;
    logic [AW-1:0]        cur_addr, wr_addr, rd_addr;
    logic [DW-1:0]        cur_data, prv_data, wr_data;
    logic                 wr_en;
    logic [NUM_LANES-1:0] wr_mask;

    assign ctl_in = '{sel_n: sel_n, sel_p: sel_p, wr_n: wr_n, rd_n: rd_n, lane_n: lane_n};

    psram_sampler #(.AW(AW), .DW(DW)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .ctl_in   (ctl_in),
        .addr_in  (addr),
        .data_in  (data_in),
        .cur_ctl  (cur_ctl),
        .prv_ctl  (prv_ctl),
        .cur_addr (cur_addr),
        .cur_data (cur_data),
        .prv_data (prv_data)
    );

    psram_seq #(.AW(AW), .DW(DW), .PRECHG_MIN(PRECHG_MIN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cur_ctl   (cur_ctl),
        .prv_ctl   (prv_ctl),
        .cur_addr  (cur_addr),
        .cur_data  (cur_data),
        .prv_data  (prv_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .rd_addr   (rd_addr),
        .drive     (lane_drive),
        .proto_err (precharge_err)
    );

    psram_lanes #(.AW(AW), .LANE_W(LANE_W)) u_lanes (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .rd_addr (rd_addr),
        .rd_data (data_out)
    );

endmodule

// File: tb/psram_port_bench.sv
module psram_port_bench;

    localparam int AW  = 8;
    localparam int DEP = 1 << AW;
    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, sel_p = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [1:0]  lane_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic [1:0]  lane_drive;
    logic        precharge_err;

    logic [15:0] ref_mem [DEP];
    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    psram_port #(.AW(AW), .LANE_W(8), .PRECHG_MIN(3)) u_psram_port (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n), .rd_n(rd_n),
        .lane_n(lane_n), .addr(addr), .data_in(data_in), .data_out(data_out),
        .lane_drive(lane_drive), .precharge_err(precharge_err)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic [1:0] s);
        logic [15:0] r = old;
        if (!s[0]) r[7:0]  = d[7:0];
        if (!s[1]) r[15:8] = d[15:8];
        return r;
    endfunction

    task automatic deselect(bit use_p);
        if (use_p) sel_p = 1'b0; else sel_n = 1'b1;
    endtask

    task automatic idle(int n);
        sel_n = 1'b1; sel_p = 1'b1; wr_n = 1'b1; rd_n = 1'b1; lane_n = 2'b11;
        step(n);
    endtask

    // R7: select-started write, data changes mid-access, final value wins
    task automatic ce_write(logic [AW-1:0] a, logic [15:0] d, logic [1:0] s, bit use_p);
        addr = a; data_in = ~d; lane_n = s; wr_n = 1'b0; rd_n = 1'b1;
        sel_n = 1'b0; sel_p = 1'b1;
        step(3);
        data_in = d;
        step(3);
        deselect(use_p);
        ref_mem[a] = merge(ref_mem[a], d, s);
        idle(GAP);
    endtask

    // R6: strobe-started write, bus changes after the falling edge
    task automatic we_write(logic [AW-1:0] a, logic [15:0] d, logic [1:0] s);
        addr = a ^ 8'h5A; data_in = ~d; lane_n = s; wr_n = 1'b1; rd_n = 1'b1;
        sel_n = 1'b0; sel_p = 1'b1;
        step(3);
        addr = a; data_in = d; wr_n = 1'b0;
        step(3);
        addr = a ^ 8'h01; data_in = ~d;
        step(3);
        wr_n = 1'b1;
        step(2);
        deselect(1'b0);
        ref_mem[a] = merge(ref_mem[a], d, s);
        idle(GAP);
    endtask

    task automatic check_read(logic [AW-1:0] a, logic [1:0] s, string tag);
        logic [15:0] e = ref_mem[a];
        chk(lane_drive == ~s, {tag, " R2 drive"}, 32'(lane_drive), 32'(~s));
        if (!s[0]) chk(data_out[7:0] == e[7:0], {tag, " R2 low byte"}, 32'(data_out[7:0]), 32'(e[7:0]));
        if (!s[1]) chk(data_out[15:8] == e[15:8], {tag, " R2 high byte"}, 32'(data_out[15:8]), 32'(e[15:8]));
    endtask

    // R4: select-started read, address changes later are ignored
    task automatic ce_read(logic [AW-1:0] a, logic [1:0] s);
        addr = a; lane_n = s; wr_n = 1'b1; rd_n = 1'b0;
        sel_n = 1'b0; sel_p = 1'b1;
        step(3);
        addr = a ^ 8'hA5;
        step(3);
        check_read(a, s, "R4");
        deselect(1'b1);
        idle(GAP);
    endtask

    // R5: read-strobe-started read
    task automatic oe_read(logic [AW-1:0] a, logic [1:0] s);
        addr = a ^ 8'h33; lane_n = s; wr_n = 1'b1; rd_n = 1'b1;
        sel_n = 1'b0; sel_p = 1'b1;
        step(3);
        addr = a; rd_n = 1'b0;
        step(3);
        addr = a ^ 8'h0F;
        step(3);
        check_read(a, s, "R5");
        deselect(1'b0);
        idle(GAP);
    endtask

    task automatic gap_access(int g);
        addr = 8'h10; lane_n = 2'b00; wr_n = 1'b1; rd_n = 1'b0;
        sel_n = 1'b0; sel_p = 1'b1;
        step(3);
        sel_n = 1'b1;
        step(g);
        sel_n = 1'b0;
        step(3);
        idle(GAP);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        step(1);
        do_reset();
        chk(lane_drive == 2'b00, "R9 reset drive", 32'(lane_drive), 0);
        chk(precharge_err == 1'b0, "R9 reset err", 32'(precharge_err), 0);

        // fill the array
        for (int i = 0; i < DEP; i++) begin
            ref_mem[i] = 16'h0;
            ce_write(AW'(i), 16'($urandom), 2'b00, i[0]);
        end

        // R3: masked writes keep the other lane
        we_write(8'h20, 16'hABCD, 2'b10);
        ce_read(8'h20, 2'b00);
        ce_write(8'h21, 16'h1234, 2'b01, 1'b0);
        oe_read(8'h21, 2'b00);
        oe_read(8'h21, 2'b10);
        ce_read(8'h20, 2'b11);

        // R1: standby through each select pin, all strobes asserted
        sel_n = 1'b1; sel_p = 1'b1; wr_n = 1'b0; rd_n = 1'b0; lane_n = 2'b00;
        addr = 8'h30; data_in = 16'hDEAD;
        step(4);
        chk(lane_drive == 2'b00, "R1 standby primary", 32'(lane_drive), 0);
        sel_n = 1'b0; sel_p = 1'b0;
        step(4);
        chk(lane_drive == 2'b00, "R1 standby secondary", 32'(lane_drive), 0);
        idle(GAP);
        ce_read(8'h30, 2'b00);

        // R10: both strobes low is a write
        addr = 8'h31; data_in = 16'h5AA5; lane_n = 2'b00; wr_n = 1'b0; rd_n = 1'b0;
        sel_n = 1'b0; sel_p = 1'b1;
        step(4);
        chk(lane_drive == 2'b00, "R10 priority drive", 32'(lane_drive), 0);
        sel_n = 1'b1;
        ref_mem[8'h31] = 16'h5AA5;
        idle(GAP);
        oe_read(8'h31, 2'b00);

        // random mix
        for (int k = 0; k < 80; k++) begin
            logic [AW-1:0] a = AW'($urandom);
            logic [15:0]   d = 16'($urandom);
            logic [1:0]    s = 2'($urandom);
            case ($urandom % 4)
                0: ce_write(a, d, s, 1'($urandom));
                1: we_write(a, d, s);
                2: ce_read(a, s);
                default: oe_read(a, s);
            endcase
        end
        chk(precharge_err == 1'b0, "R8 no error with legal gaps", 32'(precharge_err), 0);

        // R8: gap one short of minimum
        gap_access(2);
        chk(precharge_err == 1'b1, "R8 short gap", 32'(precharge_err), 1);
        idle(10);
        chk(precharge_err == 1'b1, "R9 sticky", 32'(precharge_err), 1);
        do_reset();
        chk(precharge_err == 1'b0, "R9 cleared by reset", 32'(precharge_err), 0);
        // R8: exact minimum gap accepted
        gap_access(3);
        chk(precharge_err == 1'b0, "R8 exact gap", 32'(precharge_err), 0);
        ce_read(8'h20, 2'b00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule